// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block sits between a 32-bit register bus and a separate serial frame engine. Software programs the line settings in a control word and queues bytes through a transmit-data location. It drains received bytes through a receive-data location and watches a status word. The block holds both byte queues and hands bytes to and from the frame engine through push/pop strobes. It keeps five sticky event flags, cleared by writing 1, and drives one level interrupt from two of those flags and their enables.

Bus accesses complete in one cycle. Read data is combinational in the cycle that `bus_rd` is high. A read of the receive-data location dequeues one byte at the clock edge that ends the access. The frame engine sees the stored control word on `ctl_out`. It uses that word for framing, loopback and flow control, which this block does not do itself. The two DMA enable bits are stored and have no other effect.

Top module: `sercon_regs`

## Requirements
- R1: After reset, the control word reads 0, `irq` is 0, and the status word masked with 0x1FCFC reads 0x420 (both queues empty, level 0, no errors) while `cts_in` and `rts_in` are 0.
- R2: Offset 0x000 is the control word. Only bits 0-2, 4-6, 12 and 14-20 are stored and driven on `ctl_out`; all other bits read 0. Bit 15 is the enable, bit 14 the level select, bits 16/17 the DMA enables, bits 18/19 the receive/transmit interrupt enables, and bit 20 loopback.
- R3: A write to offset 0x008 queues `bus_wdata[7:0]`. `tx_valid` is high only while control bit 15 is 1 and the queue holds data. `tx_byte` presents the bytes in write order, and each `tx_pop` removes one.
- R4: A write to 0x008 while the transmit queue is full is discarded and sets status bit 3.
- R5: A read of 0x004 returns the oldest received byte in bits 7:0 with zeros above and removes it. A read of 0x004 while the queue is empty returns 0 and leaves the queue unchanged.
- R6: `rx_push` while control bit 15 is 0 is ignored. `rx_push` while the receive queue is full drops the byte and sets status bit 2.
- R7: `rx_push` with `rx_err` high while enabled sets status bit 4, and the byte is still queued.
- R8: Writing 1 to status bits 0-4 at offset 0x00C clears them; writing 0 leaves them unchanged. If a set condition holds in the same cycle, the set wins.
- R9: Status bit 0 is set in every cycle the receive queue is non-empty. Status bit 1 is set in every cycle the transmit queue holds fewer than half its depth.
- R10: `irq` = (status bit 0 AND control bit 18) OR (status bit 1 AND control bit 19).
- R11: Status bits 16:11 show the transmit queue fill when control bit 14 is 1, and the receive queue fill when it is 0.
- R12: Status bit 5 = receive queue empty, bit 6 = transmit queue full, bit 10 = transmit queue empty.
- R13: Status bit 7 follows `cts_in` and bit 8 follows `rts_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| tx_byte | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit byte available to the frame engine |
| tx_pop | input | 1 | Frame engine takes tx_byte |
| rx_byte | input | 8 | Byte received by the frame engine |
| rx_push | input | 1 | Frame engine delivers rx_byte |
| rx_err | input | 1 | Delivered byte had a framing, parity or break fault |
| cts_in | input | 1 | Clear-to-send line state |
| rts_in | input | 1 | Request-to-send line state from the frame engine |
| ctl_out | output | 21 | Stored control word for the frame engine |
| irq | output | 1 | Level interrupt |

## Verification
The transmit queue is filled one byte at a time from empty to one past full. Each step is compared with the arithmetic fill, the full and empty flags and the write-error flag. This run separates the level select, the off-by-one at the full boundary and the discard of the extra byte. The receive queue gets a sweep of distinct byte values with one faulted byte and an extra push past full. Reading them back shows ordering, the zero upper bits, overrun and line-error setting, and the empty-read case. Each interrupt-pending flag is cleared by writing 0, then 1, while its set condition is false, and then its set condition is restored. This tells write-1-clear apart from plain write and shows that `irq` follows each enable.

// File: rtl/sercon_pkg.sv
package sercon_pkg;
  // Register byte offsets
  localparam int unsigned OFS_CTL  = 32'h000;
  localparam int unsigned OFS_RXD  = 32'h004;
  localparam int unsigned OFS_TXD  = 32'h008;
  localparam int unsigned OFS_STAT = 32'h00C;

  // Control word
  localparam int unsigned CTL_W       = 21;
  localparam logic [31:0] CTL_MASK    = 32'h001F_D077;
  localparam int unsigned CB_LVL_TX   = 14;
  localparam int unsigned CB_ENABLE   = 15;
  localparam int unsigned CB_RX_IE    = 18;
  localparam int unsigned CB_TX_IE    = 19;

  // Sticky flags, index equals status bit position
  localparam int unsigned NFLAG   = 5;
  localparam int unsigned FL_RIP  = 0;
  localparam int unsigned FL_TIP  = 1;
  localparam int unsigned FL_OVR  = 2;
  localparam int unsigned FL_TXE  = 3;
  localparam int unsigned FL_LERR = 4;

  // Other status positions
  localparam int unsigned SB_RX_EMPTY = 5;
  localparam int unsigned SB_TX_FULL  = 6;
  localparam int unsigned SB_CTS      = 7;
  localparam int unsigned SB_RTS      = 8;
  localparam int unsigned SB_TX_EMPTY = 10;
  localparam int unsigned SB_LVL_LO   = 11;
  localparam int unsigned LEVEL_W     = 6;
endpackage

// File: rtl/sercon_fifo.sv
module sercon_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [IW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign dout    = mem[rd_q];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == IW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R4: a push into a full queue leaves it full with the same fill
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(cnt_q)));

  // R5: a pop from an empty queue with no push keeps it empty
  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/sercon_flags.sv
module sercon_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_r, q_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb q_d[i] = set[i] | (q_r[i] & ~clr[i]);

    // R8: a clear with no concurrent set leaves the flag low
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/sercon_regs.sv
module sercon_regs
  import sercon_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_pop,
  input  logic [7:0]        rx_byte,
  input  logic              rx_push,
  input  logic              rx_err,
  input  logic              cts_in,
  input  logic              rts_in,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              irq
);
  localparam int unsigned TXC_W   = $clog2(TX_DEPTH + 1);
  localparam int unsigned RXC_W   = $clog2(RX_DEPTH + 1);
  localparam int unsigned TX_HALF = TX_DEPTH / 2;

  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             sel_ctl, sel_rxd, sel_txd, sel_stat;
  logic             en;
  logic [7:0]       rx_head;
  logic [TXC_W-1:0] tx_cnt;
  logic [RXC_W-1:0] rx_cnt;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic             tx_wr, rx_rd, rx_acc;
  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;
  logic [LEVEL_W-1:0] lvl;
  logic [31:0]      stat_w;

  // Address decode
  assign sel_ctl  = (bus_addr == ADDR_W'(OFS_CTL));
  assign sel_rxd  = (bus_addr == ADDR_W'(OFS_RXD));
  assign sel_txd  = (bus_addr == ADDR_W'(OFS_TXD));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));

  assign en     = ctl_q[CB_ENABLE];
  assign tx_wr  = bus_wr && sel_txd;
  assign rx_rd  = bus_rd && sel_rxd;
  assign rx_acc = rx_push && en;

  // Control word
  always_comb begin
    ctl_d = ctl_q;
    if (bus_wr && sel_ctl) ctl_d = bus_wdata[CTL_W-1:0] & CTL_MASK[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_out = ctl_q;

  // Byte queues
  sercon_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_wr),
    .din   (bus_wdata[7:0]),
    .pop   (tx_pop && en),
    .dout  (tx_byte),
    .count (tx_cnt),
    .empty (tx_empty),
    .full  (tx_full)
  );

  sercon_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_acc),
    .din   (rx_byte),
    .pop   (rx_rd),
    .dout  (rx_head),
    .count (rx_cnt),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign tx_valid = en && !tx_empty;

  // Sticky event flags
  always_comb begin
    fl_set          = '0;
    fl_set[FL_RIP]  = !rx_empty;
    fl_set[FL_TIP]  = (32'(tx_cnt) < TX_HALF);
    fl_set[FL_OVR]  = rx_acc && rx_full;
    fl_set[FL_TXE]  = tx_wr && tx_full;
    fl_set[FL_LERR] = rx_acc && rx_err;
    fl_clr          = (bus_wr && sel_stat) ? bus_wdata[NFLAG-1:0] : '0;
  end

  sercon_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (fl_set),
    .clr   (fl_clr),
    .q     (fl_q)
  );

  assign irq = (fl_q[FL_RIP] && ctl_q[CB_RX_IE]) || (fl_q[FL_TIP] && ctl_q[CB_TX_IE]);

  // Status word and read mux
  assign lvl = ctl_q[CB_LVL_TX] ? LEVEL_W'(tx_cnt) : LEVEL_W'(rx_cnt);

  always_comb begin
    stat_w                           = '0;
    stat_w[NFLAG-1:0]                = fl_q;
    stat_w[SB_RX_EMPTY]              = rx_empty;
    stat_w[SB_TX_FULL]               = tx_full;
    stat_w[SB_CTS]                   = cts_in;
    stat_w[SB_RTS]                   = rts_in;
    stat_w[SB_TX_EMPTY]              = tx_empty;
    stat_w[SB_LVL_LO +: LEVEL_W]     = lvl;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_ctl)       bus_rdata = 32'(ctl_q);
      else if (sel_rxd)  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
      else if (sel_stat) bus_rdata = stat_w;
    end
  end

  // R4: write into a full transmit queue raises the write-error flag
  p_txerr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> fl_q[FL_TXE]);

  // R5: empty receive read returns zero
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |-> (bus_rdata == 32'd0));

  // R6: enabled push into full receive queue raises overrun
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && en && rx_full) |=> fl_q[FL_OVR]);

  // R7: faulted byte raises line error
  p_line_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && en && rx_err) |=> fl_q[FL_LERR]);

  // R9: a non-empty receive queue keeps the receive pending flag set
  p_rx_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_empty |=> fl_q[FL_RIP]);

  // R10: no interrupt with both enables off
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CB_RX_IE] && !ctl_q[CB_TX_IE]) |-> !irq);
endmodule

// File: tb/sercon_regs_tb.sv
module sercon_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_byte, rx_byte;
  logic        tx_valid, tx_pop, rx_push, rx_err, cts_in, rts_in, irq;
  logic [20:0] ctl_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercon_regs #(.ADDR_W(12), .TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .rx_byte(rx_byte), .rx_push(rx_push), .rx_err(rx_err),
    .cts_in(cts_in), .rts_in(rts_in), .ctl_out(ctl_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b, input logic e);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b; rx_err = e;
    @(negedge clk);
    rx_push = 1'b0; rx_err = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    tx_pop = 0; rx_push = 0; rx_byte = '0; rx_err = 0; cts_in = 0; rts_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h00C, d);  chk("R1 status", d & 32'h0001_FCFC, 32'h0000_0420);
    rd(12'h000, d);  chk("R1 ctl", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 control field mask and readback
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d);  chk("R2 readback", d, 32'h001F_D077);
    chk("R2 ctl_out", 32'(ctl_out), 32'h001F_D077);
    wr(12'h000, 32'h0);

    // R13 line state bits
    cts_in = 1; rts_in = 0;
    rd(12'h00C, d);  chk("R13 cts", {30'd0, d[8:7]}, 32'h1);
    cts_in = 0; rts_in = 1;
    rd(12'h00C, d);  chk("R13 rts", {30'd0, d[8:7]}, 32'h2);
    rts_in = 0;

    // TX fill sweep with level select on transmit, queue disabled
    wr(12'h000, 32'h0000_4000);
    for (int k = 1; k <= DEPTH + 1; k++) begin
      int exp_lvl;
      exp_lvl = (k < DEPTH) ? k : DEPTH;
      wr(12'h008, 32'h30 + k);
      rd(12'h00C, d);
      chk("R11 tx level", 32'(d[16:11]), 32'(exp_lvl));
      chk("R12 tx full", 32'(d[6]), 32'(k >= DEPTH));
      chk("R12 tx empty", 32'(d[10]), 32'h0);
      chk("R4 tx error", 32'(d[3]), 32'(k > DEPTH));
    end
    chk("R3 gated by enable", 32'(tx_valid), 32'h0);

    // R8 write-one-clear on transmit pending (queue at or above half)
    wr(12'h00C, 32'h0);
    rd(12'h00C, d);  chk("R8 write 0 keeps", 32'(d[1]), 32'h1);
    wr(12'h00C, 32'h0000_000A);
    rd(12'h00C, d);
    chk("R8 tip cleared", 32'(d[1]), 32'h0);
    chk("R8 txerr cleared", 32'(d[3]), 32'h0);

    // R3 drain in order; R9/R10 transmit pending returns below half
    wr(12'h000, 32'h0008_C000);
    chk("R10 irq off", 32'(irq), 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 tx_valid", 32'(tx_valid), 32'h1);
      chk("R3 tx order", 32'(tx_byte), 32'h31 + i);
      pop_tx();
    end
    chk("R3 drained", 32'(tx_valid), 32'h0);
    rd(12'h00C, d);
    chk("R9 tip set", 32'(d[1]), 32'h1);
    chk("R12 tx empty", 32'(d[10]), 32'h1);
    chk("R10 irq tx", 32'(irq), 32'h1);

    // RX sweep, level select on receive
    wr(12'h000, 32'h0000_8000);
    wr(12'h00C, 32'h1F);
    for (int i = 0; i <= DEPTH; i++) begin
      int exp_lvl;
      exp_lvl = (i + 1 < DEPTH) ? i + 1 : DEPTH;
      push_rx(8'(i * 7 + 3), i == 5);
      rd(12'h00C, d);
      chk("R11 rx level", 32'(d[16:11]), 32'(exp_lvl));
      chk("R6 overrun", 32'(d[2]), 32'(i == DEPTH));
      chk("R7 line err", 32'(d[4]), 32'(i >= 5));
    end
    rd(12'h00C, d);
    chk("R9 rip set", 32'(d[0]), 32'h1);
    chk("R12 rx not empty", 32'(d[5]), 32'h0);
    chk("R10 irq rx off", 32'(irq), 32'h0);
    wr(12'h000, 32'h0004_8000);
    chk("R10 irq rx on", 32'(irq), 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(12'h004, d);
      chk("R5 rx data", d, 32'(8'(i * 7 + 3)));
    end
    rd(12'h004, d);  chk("R5 empty read", d, 32'h0);
    rd(12'h00C, d);
    chk("R5 level after empty read", 32'(d[16:11]), 32'h0);
    chk("R12 rx empty", 32'(d[5]), 32'h1);
    chk("R8 rip sticky", 32'(d[0]), 32'h1);
    wr(12'h00C, 32'h0000_0015);
    rd(12'h00C, d);
    chk("R8 rip cleared", 32'(d[0]), 32'h0);
    chk("R8 ovr cleared", 32'(d[2]), 32'h0);
    chk("R8 lerr cleared", 32'(d[4]), 32'h0);
    chk("R10 irq cleared", 32'(irq), 32'h0);

    // R6 push while disabled is ignored
    wr(12'h000, 32'h0);
    push_rx(8'hA5, 1'b1);
    rd(12'h00C, d);
    chk("R6 disabled push", d & 32'h0001_F835, 32'h0000_0020);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule